// File: doc/BRIEF.md
# Carry-Save Radix-2 Montgomery Multiplier

This block computes the radix-2 Montgomery product of two binary operands A and B. The modulus N is odd and K bits wide. The loop runs K+2 times, so the block returns a value congruent to A·B·2^-(K+2) mod N. That value needs no closing subtraction of N. The host places A, B and N on the inputs and pulses `start` for one cycle. The block then runs on its own and raises `done` for one cycle, with the binary product on `result`.

The running total is kept as two words, a sum word and a carry word, so no addition inside the loop propagates a carry. Each iteration passes through two cascaded 3-to-2 carry-save levels: the first adds A_i·B and the second adds q_i·N. Both words are then shifted right by one bit. Once the loop ends, the same two levels fold the carry word into the sum word, two half-add steps per cycle, until the carry word is zero. The number of cycles this takes depends on the data, and no separate carry-propagate adder is needed.

Top module: `mont_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: For an odd N and A, B < N, `result` is the exact output of this recurrence: S=0, then for i = 0..K+1, S = S + A_i·B, and if S is odd S = S + N, then S = S/2. Bits A_i with i >= K are zero. Hence result·2^(K+2) ≡ A·B (mod N).
- R3: With A, B < N, `result` is always below 2N. No final subtraction is applied.
- R4: A `start` sampled while idle is accepted. `busy` is 1 from the next cycle, and the loop lasts exactly K+2 cycles before conversion begins.
- R5: When the carry word is zero after the loop (for example A = 0 or B = 0), `done` rises at the K+3rd rising edge after the edge that accepted `start`. In every case, `done` comes no later than about K/2 further cycles.
- R6: `done` is high for exactly one cycle. `result` changes only in a cycle in which `done` is high, and it holds until the next completion.
- R7: A `start` pulse while `busy` is 1 is ignored: the operation in flight finishes with its original operands.
- R8: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; operands sampled with it |
| a_in | input | K | Multiplier operand A |
| b_in | input | K | Multiplicand operand B |
| n_in | input | K | Odd modulus N |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | K+2 | Montgomery product, below 2N |

## Verification
Completion and acceptance of the next request can fall in the same cycle. The registered `done` is high while the controller is already idle, so a `start` in that cycle must be taken. The bench provokes this by raising a new request in the very cycle where it sees `done`. It judges the case by a correct second product and `busy` in the following cycle. A second collision, `start` arriving mid-loop, is provoked with different operands and judged by the first product coming out unchanged.

// File: rtl/mont_pkg.sv
package mont_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_FOLD = 2'd2
    } mm_state_e;

endpackage

// File: rtl/mont_csa.sv
// Carry-save 3:2 compressor: sum + carry == x + y + z (modulo 2^W).
module mont_csa #(
    parameter int W = 18
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = x[i] ^ y[i] ^ z[i];
        if (i > 0) begin : g_cy
            assign carry[i] = (x[i-1] & y[i-1]) | (x[i-1] & z[i-1]) | (y[i-1] & z[i-1]);
        end
    end

endmodule

// File: rtl/mont_step.sv
// Two cascaded carry-save levels. In loop mode they add A_i*B then q_i*N and
// shift right; in fold mode both extra operands are zero and no shift occurs.
module mont_step #(
    parameter int W = 18
) (
    input  logic [W-1:0] ss,
    input  logic [W-1:0] sc,
    input  logic [W-1:0] bm,
    input  logic [W-1:0] nm,
    input  logic         a_bit,
    input  logic         fold,
    output logic [W-1:0] ss_nx,
    output logic [W-1:0] sc_nx
);
    logic         q_bit;
    logic [W-1:0] op_b, op_n;
    logic [W-1:0] s1, c1, s2, c2;

    // Parity of the sum after adding A_i*B decides whether N is added.
    assign q_bit = ss[0] ^ sc[0] ^ (a_bit & bm[0]);
    assign op_b  = (!fold && a_bit) ? bm : '0;
    assign op_n  = (!fold && q_bit) ? nm : '0;

    mont_csa #(.W(W)) u_lvl1 (
        .x(ss), .y(sc), .z(op_b), .sum(s1), .carry(c1)
    );

    mont_csa #(.W(W)) u_lvl2 (
        .x(s1), .y(c1), .z(op_n), .sum(s2), .carry(c2)
    );

    always_comb begin
        if (fold) begin
            ss_nx = s2;
            sc_nx = c2;
        end else begin
            ss_nx = {1'b0, s2[W-1:1]};
            sc_nx = {1'b0, c2[W-1:1]};
        end
    end

endmodule

// File: rtl/mont_mul.sv
module mont_mul
    import mont_pkg::*;
#(
    parameter int K = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [K-1:0]   a_in,
    input  logic [K-1:0]   b_in,
    input  logic [K-1:0]   n_in,
    output logic           busy,
    output logic           done,
    output logic [K+1:0]   result
);
    localparam int W  = K + 2;
    localparam int CW = $clog2(K + 2);
    localparam logic [CW-1:0] LAST = CW'(K + 1);

    typedef struct packed {
        mm_state_e     st;
        logic [CW-1:0] cnt;
        logic [K-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  n;
        logic [W-1:0]  ss;
        logic [W-1:0]  sc;
        logic          done;
        logic [W-1:0]  res;
    } regs_t;

    regs_t st_d, st_q;

    logic [W-1:0] ss_nx, sc_nx;
    logic [W-1:0] n_hold;

    mont_step #(.W(W)) u_step (
        .ss    (st_q.ss),
        .sc    (st_q.sc),
        .bm    (st_q.b),
        .nm    (st_q.n),
        .a_bit (st_q.a[0]),
        .fold  (st_q.st == ST_FOLD),
        .ss_nx (ss_nx),
        .sc_nx (sc_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (start) begin
                    st_d.st  = ST_LOOP;
                    st_d.cnt = '0;
                    st_d.a   = a_in;
                    st_d.b   = {2'b00, b_in};
                    st_d.n   = {2'b00, n_in};
                    st_d.ss  = '0;
                    st_d.sc  = '0;
                end
            end
            ST_LOOP: begin
                st_d.ss  = ss_nx;
                st_d.sc  = sc_nx;
                st_d.a   = st_q.a >> 1;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.st = ST_FOLD;
                end
            end
            ST_FOLD: begin
                if (st_q.sc == '0) begin
                    st_d.done = 1'b1;
                    st_d.res  = st_q.ss;
                    st_d.st   = ST_IDLE;
                end else begin
                    st_d.ss = ss_nx;
                    st_d.sc = sc_nx;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, cnt: '0, a: '0, b: '0, n: '0,
                      ss: '0, sc: '0, done: 1'b0, res: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.st != ST_IDLE);
    assign done   = st_q.done;
    assign result = st_q.res;
    assign n_hold = st_q.n;

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int K = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [K+1:0] result,
    input logic [K+1:0] n_val
);
    localparam int MAXL = 2 * K + 10;

    logic [15:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start && !busy) begin
            lat_q <= 16'd1;
        end else if (busy) begin
            lat_q <= lat_q + 16'd1;
        end
    end

    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    a_r3_below_2n: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, result} < ({1'b0, n_val} << 1)));

    a_r5_latency_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q >= 16'(K + 3)));

    a_r5_latency_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_q <= 16'(MAXL)));

endmodule

bind mont_mul mont_mul_chk #(.K(K)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .n_val  (n_hold)
);

// File: tb/mont_mul_bench.sv
`timescale 1ns/1ps
module mont_mul_bench;
    localparam int K    = 16;
    localparam int W    = K + 2;
    localparam int MINL = K + 4;     // negedges from start drive to done seen
    localparam int MAXL = 2 * K + 12;

    // {a, b, n}
    localparam logic [3*K-1:0] VEC [8] = '{
        {16'h1234, 16'h5678, 16'hFFF1},
        {16'hFFF0, 16'hFFF0, 16'hFFF1},
        {16'h0001, 16'h0001, 16'h8001},
        {16'h7FFF, 16'h0003, 16'h8001},
        {16'hABCD, 16'h1357, 16'hC001},
        {16'h0002, 16'h0004, 16'h0007},
        {16'hFFFE, 16'h0001, 16'hFFFF},
        {16'h4000, 16'h4000, 16'h4001}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [K-1:0] a_in = '0, b_in = '0, n_in = '0;
    logic         busy, done;
    logic [W-1:0] result;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    mont_mul #(.K(K)) u_mont_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .n_in(n_in),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ref_mm(input longint a, input longint b, input longint n);
        longint s = 0;
        for (int i = 0; i < K + 2; i++) begin
            if (i < K && a[i]) s = s + b;
            if (s[0]) s = s + n;
            s = s >> 1;
        end
        return s;
    endfunction

    task automatic run(input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] n,
                       output longint res, output int lat);
        a_in  = a; b_in = b; n_in = n;
        start = 1'b1;
        lat   = 0;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 5000) check(1'b0, "watchdog", lat, MAXL);
        res = longint'(result);
    endtask

    task automatic judge(input longint a, input longint b, input longint n,
                         input longint res, input int lat);
        longint e = ref_mm(a, b, n);
        check(res == e, "R2 exact value", res, e);
        check(((res << (K + 2)) % n) == ((a * b) % n), "R2 congruence",
              (res << (K + 2)) % n, (a * b) % n);
        check(res < 2 * n, "R3 below 2N", res, 2 * n);
        check(lat >= MINL && lat <= MAXL, "R5 latency window", lat, MINL);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        longint res, res2;
        int     lat;
        logic [K-1:0] ra, rb, rn;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(result == '0, "R1 result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            run(VEC[v][3*K-1:2*K], VEC[v][2*K-1:K], VEC[v][K-1:0], res, lat);
            judge(VEC[v][3*K-1:2*K], VEC[v][2*K-1:K], VEC[v][K-1:0], res, lat);
            @(negedge clk);
            check(done == 1'b0, "R6 single-cycle done", done, 0);
            check(longint'(result) == res, "R6 result held", result, res);
        end

        for (int r = 0; r < 16; r++) begin
            rn = K'($urandom) | 16'h8001;
            ra = K'($urandom % rn);
            rb = K'($urandom % rn);
            run(ra, rb, rn, res, lat);
            judge(ra, rb, rn, res, lat);
            @(negedge clk);
        end

        // R5: zero operands give an all-zero carry word, minimum latency
        run(16'h0000, 16'h1234, 16'hFFF1, res, lat);
        check(lat == MINL, "R5 minimum latency A=0", lat, MINL);
        check(res == 0, "R2 zero product", res, 0);
        // R8: start in the cycle where done is high (no gap)
        check(done == 1'b1, "R8 done visible", done, 1);
        a_in = 16'hABCD; b_in = 16'h0000; n_in = 16'hC001;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 back-to-back accepted", busy, 1);
        check(busy == 1'b1, "R4 busy after start", busy, 1);
        lat = 1;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        check(lat == MINL, "R5 minimum latency B=0", lat, MINL);
        check(result == '0, "R8 second product", result, 0);
        @(negedge clk);

        // R4: loop length; busy must not drop before K+2 loop cycles
        a_in = 16'h1234; b_in = 16'h5678; n_in = 16'hFFF1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < K + 2; c++) begin
            check(busy == 1'b1 && done == 1'b0, "R4 busy through loop", busy, 1);
            @(negedge clk);
        end
        // R7: start while busy with other operands is ignored
        a_in = 16'h0001; b_in = 16'h0001; n_in = 16'h0007;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        res2 = ref_mm(16'h1234, 16'h5678, 16'hFFF1);
        check(longint'(result) == res2, "R7 start ignored while busy", result, res2);
        @(negedge clk);
        check(busy == 1'b0, "R7 no second run", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule